// File: doc/BRIEF.md
# Serial/Parallel Input Staging Register

This block is the entry stage of a FIFO. It collects one word of `W` bits either all at once from a parallel bus, or one bit at a time from a serial line. An active-low flag reports that the word is complete and ready to move into the storage stack. Completion of a serial word is found with a marker bit instead of a bit counter. Initialization places a single one in the top data bit. Each serial shift moves that marker one place down. When the marker falls out of bit 0 into a fifth flip-flop, the word is complete.

Everything runs on one system clock. The serial clock is an ordinary input that the block samples, and a shift happens when that sample is seen to fall. The stack controller sends a re-initialize pulse after it has taken the word. That pulse is deferred for as long as the parallel-load strobe stays high, so a word that is still being loaded is never cleared while the load is in progress.

Top module: `fifo_in_stage`

## Requirements
- R1: A synchronous `rst` sets `word` to the initial pattern (only bit W-1 set, 4'b1000 by default) and drives `full_n` high at the next clock edge.
- R2: `full_n` is low exactly when a complete word is held. It stays high after initialization and while a serial word is only partly shifted in.
- R3: At a clock edge where `pload` is high, `sclk` is low and `row_sel_n` is low, `word` takes `pdata` and `full_n` goes low. The copy repeats on every such edge for as long as `pload` stays high.
- R4: `pload` has no effect at an edge where `sclk` or `row_sel_n` is high.
- R5: A serial falling edge is `sclk` sampled high at one clock edge and low at the next. At that second edge, if `pload` and `row_sel_n` are low and `full_n` is high, `sdata` enters bit W-1 and every other bit moves one position down.
- R6: The fourth shift after initialization drives `full_n` low at the same edge. The first serial bit received ends in bit 0 and the last one in bit W-1.
- R7: While `full_n` is low, further serial falling edges leave `word` and `full_n` unchanged.
- R8: A serial falling edge causes no shift when `pload` or `row_sel_n` is high at that edge.
- R9: `reinit` high at an edge where `pload` is low restores the initial pattern and raises `full_n` at that edge.
- R10: `reinit` seen while `pload` is high is remembered. It takes effect at the first later edge at which `pload` is low, and not before that edge.
- R11: When `reinit` and a qualifying serial falling edge arrive at the same edge, initialization wins and that serial edge is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous master reset, active high |
| pdata | input | W | Parallel data word |
| pload | input | 1 | Parallel-load strobe, level sensitive |
| sdata | input | 1 | Serial data bit |
| sclk | input | 1 | Serial clock, sampled; the falling edge shifts |
| row_sel_n | input | 1 | Active-low enable for both parallel and serial entry |
| reinit | input | 1 | Re-initialize request from the stack controller |
| word | output | W | Held word; bit 0 is the first serial bit |
| full_n | output | 1 | Low when a complete word is held |

## Verification
Two events can meet in one cycle. A re-initialize request can coincide with a serial falling edge, and a parallel load can be raised while the serial clock is still high. The first case is provoked by dropping `sclk` and pulsing `reinit` on the same clock edge in the middle of a serial word. The result counts as correct only if the register returns to the initial pattern and the next four bits build a complete word with no extra shift. The second case raises `pload` while `sclk` is high and requires the register to remain unchanged. A later case holds `reinit` while a load is in progress. It requires the initialization to wait until the strobe drops.

// File: rtl/fifo_in_stage.sv
module fifo_in_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pdata,
  input  logic         pload,
  input  logic         sdata,
  input  logic         sclk,
  input  logic         row_sel_n,
  input  logic         reinit,
  output logic [W-1:0] word,
  output logic         full_n
);
  localparam logic [W-1:0] INIT = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] f;
  logic         fc;
  logic         sclk_q;
  logic         pend;

  wire sfall    = sclk_q & ~sclk;
  wire do_init  = (reinit | pend) & ~pload;
  wire do_par   = pload & ~sclk & ~row_sel_n;
  wire do_shift = sfall & ~pload & ~row_sel_n & ~fc;

  always_ff @(posedge clk) begin
    if (rst) begin
      f      <= INIT;
      fc     <= 1'b0;
      sclk_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      sclk_q <= sclk;
      pend   <= pload & (pend | reinit);
      if (do_init) begin
        f  <= INIT;
        fc <= 1'b0;
      end else if (do_par) begin
        f  <= pdata;
        fc <= 1'b1;
      end else if (do_shift) begin
        f  <= {sdata, f[W-1:1]};
        fc <= f[0];
      end
    end
  end

  assign word   = f;
  assign full_n = ~fc;
endmodule

// File: rtl/fifo_in_stage_chk.sv
module fifo_in_stage_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] pdata,
  input logic         pload,
  input logic         sdata,
  input logic         sclk,
  input logic         row_sel_n,
  input logic         reinit,
  input logic [W-1:0] word,
  input logic         full_n,
  input logic         pend
);
  localparam logic [W-1:0] INIT = {1'b1, {(W-1){1'b0}}};

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (full_n && word == INIT));

  a_r3_parallel_copy: assert property (@(posedge clk) disable iff (rst)
    (pload && !sclk && !row_sel_n) |=> (!full_n && word == $past(pdata)));

  a_r4_load_blocked: assert property (@(posedge clk) disable iff (rst)
    (pload && (sclk || row_sel_n)) |=> ($stable(word) && $stable(full_n)));

  a_r5_shift_in: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sclk) && !sclk && !pload && !row_sel_n && full_n && !reinit && !pend)
    |=> (word[W-1] == $past(sdata) && word[W-2:0] == $past(word[W-1:1])));

  a_r7_hold_full: assert property (@(posedge clk) disable iff (rst)
    (!full_n && !pload && !reinit && !pend) |=> ($stable(word) && !full_n));

  a_r9_reinit: assert property (@(posedge clk) disable iff (rst)
    (reinit && !pload) |=> (full_n && word == INIT));

  a_r10_deferred: assert property (@(posedge clk) disable iff (rst)
    (pend && !pload) |=> (full_n && word == INIT));
endmodule

bind fifo_in_stage fifo_in_stage_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .pdata(pdata), .pload(pload), .sdata(sdata),
  .sclk(sclk), .row_sel_n(row_sel_n), .reinit(reinit), .word(word),
  .full_n(full_n), .pend(pend)
);

// File: tb/tb_fifo_in_stage.sv
module tb_fifo_in_stage;
  localparam int W = 4;
  localparam logic [W-1:0] INIT = 4'b1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] pdata = '0;
  logic pload = 1'b0, sdata = 1'b0, sclk = 1'b0, row_sel_n = 1'b0, reinit = 1'b0;
  logic [W-1:0] word;
  logic full_n;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fifo_in_stage #(.W(W)) dut (
    .clk(clk), .rst(rst), .pdata(pdata), .pload(pload), .sdata(sdata),
    .sclk(sclk), .row_sel_n(row_sel_n), .reinit(reinit), .word(word), .full_n(full_n)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [W-1:0] aw, input logic af,
                     input logic [W-1:0] ew, input logic ef);
    n_chk++;
    if (aw !== ew || af !== ef) begin
      n_fail++;
      $display("FAIL %s: word=%b full_n=%b expected word=%b full_n=%b", req, aw, af, ew, ef);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; pload = 1'b0; sclk = 1'b0; reinit = 1'b0; row_sel_n = 1'b0;
    tick(); rst = 1'b0;
  endtask

  task automatic sbit(input logic b);
    sclk = 1'b1; sdata = b; tick();
    sclk = 1'b0; tick();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", word, full_n, INIT, 1'b1);
  endtask

  task automatic t_parallel();
    do_reset();
    for (int i = 0; i < 4; i++) begin
      logic [W-1:0] v = W'($urandom);
      pdata = v; pload = 1'b1; tick();
      chk("R3", word, full_n, v, 1'b0);
    end
    pdata = 4'b0101; tick();
    chk("R3 repeat", word, full_n, 4'b0101, 1'b0);
    pload = 1'b0; tick();
  endtask

  task automatic t_par_blocked();
    do_reset();
    sclk = 1'b1; tick();
    pdata = 4'b0110; pload = 1'b1; tick();
    chk("R4 sclk high", word, full_n, INIT, 1'b1);
    pload = 1'b0; sclk = 1'b0; tick();
    do_reset();
    row_sel_n = 1'b1; pload = 1'b1; tick();
    chk("R4 row_sel_n high", word, full_n, INIT, 1'b1);
    pload = 1'b0; row_sel_n = 1'b0; tick();
  endtask

  task automatic t_serial();
    for (int k = 0; k < 4; k++) begin
      logic [W-1:0] v = W'($urandom);
      do_reset();
      sbit(v[0]);
      chk("R5 one shift", word, full_n, {v[0], 3'b100}, 1'b1);
      sbit(v[1]);
      sbit(v[2]);
      chk("R2 three shifts", word, full_n, {v[2], v[1], v[0], 1'b1}, 1'b1);
      sbit(v[3]);
      chk("R6 complete", word, full_n, v, 1'b0);
      sbit(~v[3]); sbit(1'b1);
      chk("R7 full ignores sclk", word, full_n, v, 1'b0);
    end
  endtask

  task automatic t_serial_blocked();
    do_reset();
    row_sel_n = 1'b1; sbit(1'b0);
    chk("R8 row_sel_n", word, full_n, INIT, 1'b1);
    row_sel_n = 1'b0;
    sclk = 1'b1; sdata = 1'b0; tick();
    sclk = 1'b0; pload = 1'b1; row_sel_n = 1'b1; tick();
    chk("R8 pload", word, full_n, INIT, 1'b1);
    pload = 1'b0; row_sel_n = 1'b0; tick();
  endtask

  task automatic t_reinit();
    do_reset();
    pdata = 4'b0011; pload = 1'b1; tick(); pload = 1'b0; tick();
    reinit = 1'b1; tick(); reinit = 1'b0;
    chk("R9", word, full_n, INIT, 1'b1);
  endtask

  task automatic t_reinit_deferred();
    do_reset();
    pdata = 4'b1110; pload = 1'b1; tick();
    reinit = 1'b1; tick(); reinit = 1'b0;
    chk("R10 still held", word, full_n, 4'b1110, 1'b0);
    tick();
    chk("R10 held two", word, full_n, 4'b1110, 1'b0);
    pload = 1'b0; tick();
    chk("R10 applied", word, full_n, INIT, 1'b1);
  endtask

  task automatic t_reinit_vs_shift();
    do_reset();
    sbit(1'b1); sbit(1'b0);
    sclk = 1'b1; sdata = 1'b1; tick();
    sclk = 1'b0; reinit = 1'b1; tick(); reinit = 1'b0;
    chk("R11 init wins", word, full_n, INIT, 1'b1);
    sbit(1'b0); sbit(1'b1); sbit(1'b1);
    chk("R11 no stray shift", word, full_n, {1'b1, 1'b1, 1'b0, 1'b1}, 1'b1);
    sbit(1'b0);
    chk("R11 word", word, full_n, 4'b0110, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_parallel();
    t_par_blocked();
    t_serial();
    t_serial_blocked();
    t_reinit();
    t_reinit_deferred();
    t_reinit_vs_shift();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: word=%b full_n=%b expected completion", word, full_n);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule